// File: doc/BRIEF.md
# Virtual-Channel Conversion Sequencer

This block connects a 32-bit word-addressed register bus to a 12-bit successive-approximation converter core. Software sets up a set of virtual channels. Each one carries an enable bit and a selector that names one of the physical analog inputs. Software then writes a mask of virtual channels to a start register. For each accepted request the controller issues a one-cycle start pulse to the converter, with the selected input. It then waits for the converter's done strobe and files the 12-bit code in that virtual channel's result word. Filing the code raises a fresh-result flag in that word and sets the channel's bit in a sticky status word.

A global power-down bit in the configuration word holds the converter idle, and it is set out of reset. Requests that arrive while power-down is set, or that name a disabled channel, are dropped. When several requests are outstanding together, they run one at a time, lowest virtual channel first. Reading a result word consumes its fresh flag. Status bits are cleared by writing ones to them.

Top module: `adc_vch_ctrl`

## Requirements
- R1: After reset the configuration word (word 16) reads 0x0000_0008, which means power-down is set. The status word, every channel-setup word and every result word read zero.
- R2: The channel-setup word for virtual channel n is at word 48+n. Bits [2:0] hold the physical input selector and bit 15 holds the enable. All other bits are discarded and read as zero.
- R3: Writing a one to bit n of the start register (word 13) for an enabled channel while power-down is clear produces a one-cycle `conv_start` pulse. During that pulse, `conv_sel` carries channel n's selector.
- R4: When the converter raises `conv_done`, the result word at 64+n reads {bit 31 = 1, bits [11:0] = converter code}, with zeros elsewhere. Bit n of the status word (word 0) is set.
- R5: A start request for a disabled channel, or any start request made while power-down is set, is ignored. No conversion starts, and the status word and result words keep their values.
- R6: Outstanding requests are served one at a time in ascending virtual-channel order. A new `conv_start` never issues while a conversion is still awaiting `conv_done`.
- R7: A read of a result word returns the fresh flag as it stood and then clears it. The 12-bit code is retained.
- R8: Writing the status word clears exactly the bits written as one. Bits written as zero are unchanged.
- R9: Unmapped word addresses and the start register read as zero. Writes to unmapped addresses change no register.
- R10: Read data appears on `bus_rdata` in the cycle after the read request. In every other cycle `bus_rdata` is zero.
- R11: No `conv_start` is issued in a cycle that follows one where power-down was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read request |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_sel | output | 3 | Physical input for the conversion in progress |
| conv_done | input | 1 | Converter signals that the code is valid |
| conv_result | input | 12 | Converter code |

## Verification
The bench builds the block with its defaults: 16 virtual channels, 8 physical inputs, 12-bit codes and a 7-bit word address. This places the highest channel (word 63 for setup, word 79 for results) and every selector value from 0 to 7 under test. The converter model answers after a random delay of 1 to 21 cycles. This exercises both a done strobe in the very cycle after start and the longest conversion. Random start masks over all 16 channels, with random enables and occasional power-down, cover ordering when many requests collide.

// File: rtl/adc_vch_pkg.sv
// Shared register map and field positions for the virtual-channel converter controller.
// Assumes a word-addressed bus; offsets are word indices.
package adc_vch_pkg;
    localparam int DW         = 32;
    localparam int STATUS_OFF = 0;
    localparam int START_OFF  = 13;
    localparam int CFG_OFF    = 16;
    localparam int SETUP_BASE = 48;
    localparam int RES_BASE   = 64;
    localparam int PD_BIT     = 3;
    localparam int EN_BIT     = 15;
    localparam int FRESH_BIT  = 31;
endpackage

// File: rtl/adc_vch_pick.sv
// Lowest-index picker: returns the smallest set bit of req.
// Assumes N >= 1; purely combinational.
module adc_vch_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/adc_vch_regfile.sv
// Register file: configuration, channel setup, result words, status, start decode and read path.
// Assumes NUM_VCH <= 32 and a single-cycle bus access; reads return one cycle later.
module adc_vch_regfile
    import adc_vch_pkg::*;
#(
    parameter int NUM_VCH = 16,
    parameter int SEL_W   = 3,
    parameter int RES_W   = 12,
    parameter int ADDR_W  = 7,
    parameter int CH_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_en,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DW-1:0]                   bus_wdata,
    output logic [DW-1:0]                   bus_rdata,
    input  logic                            done_valid,
    input  logic [CH_W-1:0]                 done_ch,
    input  logic [RES_W-1:0]                done_res,
    output logic                            pd,
    output logic [NUM_VCH-1:0][SEL_W-1:0]   sel_map,
    output logic [NUM_VCH-1:0]              start_vec,
    output logic [NUM_VCH-1:0]              status_vec
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFF);
    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(START_OFF);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(CFG_OFF);
    localparam logic [ADDR_W-1:0] A_SET_LO = ADDR_W'(SETUP_BASE);
    localparam logic [ADDR_W-1:0] A_SET_HI = ADDR_W'(SETUP_BASE + NUM_VCH);
    localparam logic [ADDR_W-1:0] A_RES_LO = ADDR_W'(RES_BASE);
    localparam logic [ADDR_W-1:0] A_RES_HI = ADDR_W'(RES_BASE + NUM_VCH);
    localparam logic [DW-1:0]     CFG_RST  = DW'(1) << PD_BIT;

    logic                          wr, rd, hit_set, hit_res;
    logic [CH_W-1:0]               set_idx, res_idx;
    logic [DW-1:0]                 cfg_q, rd_val;
    logic [NUM_VCH-1:0]            en_q, fresh_q, status_q, clr_mask, set_mask;
    logic [NUM_VCH-1:0][SEL_W-1:0] sel_q;
    logic [NUM_VCH-1:0][RES_W-1:0] res_q;

    // Address decode for the two windowed register groups.
    always_comb begin
        wr      = bus_en && bus_we;
        rd      = bus_en && !bus_we;
        hit_set = (bus_addr >= A_SET_LO) && (bus_addr < A_SET_HI);
        hit_res = (bus_addr >= A_RES_LO) && (bus_addr < A_RES_HI);
        set_idx = CH_W'(bus_addr - A_SET_LO);
        res_idx = CH_W'(bus_addr - A_RES_LO);
    end

    // Configuration word; power-down is set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cfg_q <= CFG_RST;
        else if (wr && bus_addr == A_CFG) cfg_q <= bus_wdata;
    end

    // Channel setup words keep only the selector and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr && hit_set) begin
            en_q[set_idx]  <= bus_wdata[EN_BIT];
            sel_q[set_idx] <= bus_wdata[SEL_W-1:0];
        end
    end

    // Result words: a read consumes the fresh flag, a completion (later, so it wins) refills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            fresh_q <= '0;
        end else begin
            if (rd && hit_res) fresh_q[res_idx] <= 1'b0;
            if (done_valid) begin
                res_q[done_ch]   <= done_res;
                fresh_q[done_ch] <= 1'b1;
            end
        end
    end

    // Status masks: write-one-to-clear, completion sets.
    always_comb begin
        clr_mask = (wr && bus_addr == A_STATUS) ? bus_wdata[NUM_VCH-1:0] : '0;
        set_mask = done_valid ? (NUM_VCH'(1) << done_ch) : '0;
    end

    // Sticky status word.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | set_mask;
    end

    // Start requests are filtered by enable and power-down at the time of the write.
    always_comb begin
        start_vec = '0;
        if (wr && bus_addr == A_START && !cfg_q[PD_BIT])
            start_vec = bus_wdata[NUM_VCH-1:0] & en_q;
    end

    // Read value selection; unmapped and start addresses give zero.
    always_comb begin
        rd_val = '0;
        if (bus_addr == A_STATUS) begin
            rd_val = DW'(status_q);
        end else if (bus_addr == A_CFG) begin
            rd_val = cfg_q;
        end else if (hit_set) begin
            rd_val[EN_BIT]      = en_q[set_idx];
            rd_val[SEL_W-1:0]   = sel_q[set_idx];
        end else if (hit_res) begin
            rd_val[FRESH_BIT]   = fresh_q[res_idx];
            rd_val[RES_W-1:0]   = res_q[res_idx];
        end
    end

    // Registered read port, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd ? rd_val : '0;
    end

    assign pd         = cfg_q[PD_BIT];
    assign sel_map    = sel_q;
    assign status_vec = status_q;
endmodule

// File: rtl/adc_vch_seq.sv
// Conversion sequencer: queues accepted start requests and runs them one at a time,
// lowest channel first, through a start/done handshake. Assumes conv_done only while busy.
module adc_vch_seq #(
    parameter int NUM_VCH = 16,
    parameter int SEL_W   = 3,
    parameter int RES_W   = 12,
    parameter int CH_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pd,
    input  logic [NUM_VCH-1:0]            start_vec,
    input  logic [NUM_VCH-1:0][SEL_W-1:0] sel_map,
    output logic                          conv_start,
    output logic [SEL_W-1:0]              conv_sel,
    input  logic                          conv_done,
    input  logic [RES_W-1:0]              conv_result,
    output logic                          done_valid,
    output logic [CH_W-1:0]               done_ch,
    output logic [RES_W-1:0]              done_res,
    output logic                          busy,
    output logic [CH_W-1:0]               cur_ch
);
    logic [NUM_VCH-1:0] pend_q;
    logic               pick_any, grant, busy_q;
    logic [CH_W-1:0]    pick_idx, cur_q;

    adc_vch_pick #(.N(NUM_VCH), .IW(CH_W)) u_pick (
        .req (pend_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign grant = !busy_q && !pd && pick_any;

    // Pending set: drop the granted channel, add newly accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~(grant ? (NUM_VCH'(1) << pick_idx) : '0)) | start_vec;
    end

    // Handshake state: issue a start pulse on grant, release on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cur_q      <= '0;
            conv_start <= 1'b0;
            conv_sel   <= '0;
        end else begin
            conv_start <= grant;
            if (grant) begin
                busy_q   <= 1'b1;
                cur_q    <= pick_idx;
                conv_sel <= sel_map[pick_idx];
            end else if (busy_q && conv_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign done_valid = busy_q && conv_done;
    assign done_ch    = cur_q;
    assign done_res   = conv_result;
    assign busy       = busy_q;
    assign cur_ch     = cur_q;
endmodule

// File: rtl/adc_vch_ctrl.sv
// Top level of the virtual-channel converter controller: register file plus sequencer.
// Assumes a converter that answers every start pulse with exactly one done strobe.
module adc_vch_ctrl #(
    parameter int NUM_VCH  = 16,
    parameter int NUM_PHYS = 8,
    parameter int RES_W    = 12,
    parameter int ADDR_W   = 7,
    parameter int SEL_W    = $clog2(NUM_PHYS),
    parameter int CH_W     = $clog2(NUM_VCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              conv_start,
    output logic [SEL_W-1:0]  conv_sel,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result
);
    logic                          pd_w, done_valid_w, busy_w;
    logic [CH_W-1:0]               done_ch_w, cur_ch_w;
    logic [RES_W-1:0]              done_res_w;
    logic [NUM_VCH-1:0]            start_w, status_w;
    logic [NUM_VCH-1:0][SEL_W-1:0] sel_map_w;

    adc_vch_regfile #(
        .NUM_VCH(NUM_VCH), .SEL_W(SEL_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .CH_W(CH_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .done_valid (done_valid_w),
        .done_ch    (done_ch_w),
        .done_res   (done_res_w),
        .pd         (pd_w),
        .sel_map    (sel_map_w),
        .start_vec  (start_w),
        .status_vec (status_w)
    );

    adc_vch_seq #(
        .NUM_VCH(NUM_VCH), .SEL_W(SEL_W), .RES_W(RES_W), .CH_W(CH_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd          (pd_w),
        .start_vec   (start_w),
        .sel_map     (sel_map_w),
        .conv_start  (conv_start),
        .conv_sel    (conv_sel),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .done_valid  (done_valid_w),
        .done_ch     (done_ch_w),
        .done_res    (done_res_w),
        .busy        (busy_w),
        .cur_ch      (cur_ch_w)
    );
endmodule

// File: rtl/adc_vch_checker.sv
// Protocol checker bound to adc_vch_ctrl; watches the handshake, power-down gating,
// status on completion and the idle read port.
module adc_vch_checker #(
    parameter int NUM_VCH = 16,
    parameter int CH_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic [31:0]        bus_rdata,
    input logic               conv_start,
    input logic               conv_done,
    input logic               pd,
    input logic               busy,
    input logic [CH_W-1:0]    cur_ch,
    input logic [NUM_VCH-1:0] status
);
    logic [1:0] outstanding;

    // Count conversions started but not yet completed.
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else        outstanding <= outstanding + 2'(conv_start) - 2'(busy && conv_done);
    end

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> outstanding == 2'd0);

    assert_status_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> status[$past(cur_ch)]);

    assert_pd_holds_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(pd));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_en && !bus_we) |-> bus_rdata == 32'd0);
endmodule

bind adc_vch_ctrl adc_vch_checker #(.NUM_VCH(NUM_VCH), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .pd         (pd_w),
    .busy       (busy_w),
    .cur_ch     (cur_ch_w),
    .status     (status_w)
);

// File: tb/tb_adc_vch_ctrl.sv
module tb_adc_vch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [2:0]  conv_sel;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;

    int tests = 0, fails = 0;
    logic [11:0] nonce = 12'h3C5;
    int   log_sel[64];
    int   log_n = 0;

    logic        ref_en[16];
    logic [2:0]  ref_sel[16];
    logic [31:0] ref_cfg;
    logic [15:0] ref_status;
    logic [11:0] ref_res[16];
    logic        ref_fresh[16];

    adc_vch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
        .conv_sel(conv_sel), .conv_done(conv_done), .conv_result(conv_result)
    );

    always #10 clk = ~clk;

    function automatic logic [11:0] model_code(input logic [2:0] s);
        return 12'((int'(s) * 419) ^ int'(nonce));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 7'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 7'(a);
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    // Register write that also updates the bench model.
    task automatic reg_write(input int a, input logic [31:0] d);
        bus_write(a, d);
        if (a == 16) ref_cfg = d;
        if (a >= 48 && a < 64) begin
            ref_en[a-48]  = d[15];
            ref_sel[a-48] = d[2:0];
        end
        if (a == 0) ref_status = ref_status & ~d[15:0];
    endtask

    // Start request plus check of the conversion order seen at the converter.
    task automatic do_start(input logic [15:0] mask, input int wait_cyc);
        logic [15:0] eff;
        int k;
        log_n = 0;
        bus_write(13, {16'h0, mask});
        repeat (wait_cyc) @(negedge clk);
        eff = ref_cfg[3] ? 16'h0 : mask;
        for (int v = 0; v < 16; v++) if (!ref_en[v]) eff[v] = 1'b0;
        chk(eff == 0 ? "R5 start count" : "R6 start count", 32'(log_n), 32'($countones(eff)));
        k = 0;
        for (int v = 0; v < 16; v++) begin
            if (eff[v]) begin
                if (k < log_n) chk("R3/R6 selector order", 32'(log_sel[k]), 32'(ref_sel[v]));
                k++;
                ref_status[v] = 1'b1;
                ref_res[v]    = model_code(ref_sel[v]);
                ref_fresh[v]  = 1'b1;
            end
        end
    endtask

    task automatic check_all();
        logic [31:0] d;
        bus_read(0, d);
        chk("R4 status", d, {16'h0, ref_status});
        for (int v = 0; v < 16; v++) begin
            bus_read(64 + v, d);
            chk("R4/R7 result", d, {ref_fresh[v], 19'h0, ref_res[v]});
            ref_fresh[v] = 1'b0;
            bus_read(48 + v, d);
            chk("R2 setup", d, {16'h0, ref_en[v], 12'h0, ref_sel[v]});
        end
    endtask

    // Converter model: random latency 1..21 cycles, code from the selector.
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                automatic int lat = int'($urandom % 21) + 1;
                automatic logic [2:0] s = conv_sel;
                if (log_n < 64) log_sel[log_n] = int'(s);
                log_n++;
                repeat (lat - 1) @(negedge clk);
                conv_result = model_code(s);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int v = 0; v < 16; v++) begin
            ref_en[v] = 0; ref_sel[v] = 0; ref_res[v] = 0; ref_fresh[v] = 0;
        end
        ref_cfg = 32'h8; ref_status = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(16, d); chk("R1 cfg", d, 32'h8);
        bus_read(0, d);  chk("R1 status", d, 32'h0);
        bus_read(48, d); chk("R1 setup", d, 32'h0);
        bus_read(79, d); chk("R1 result", d, 32'h0);

        // R2 field masking
        reg_write(53, 32'hFFFF_FFFF);
        bus_read(53, d); chk("R2 setup mask", d, 32'h0000_8007);

        // R9 unmapped and start register
        bus_write(20, 32'hFFFF_FFFF);
        bus_write(100, 32'hFFFF_FFFF);
        bus_read(20, d);  chk("R9 unmapped", d, 32'h0);
        bus_read(100, d); chk("R9 unmapped high", d, 32'h0);
        bus_read(13, d);  chk("R9 start reads zero", d, 32'h0);
        bus_read(16, d);  chk("R9 cfg untouched", d, 32'h8);

        // R10 idle read port
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 32'h0);

        // R5/R11 power-down blocks start
        do_start(16'h0020, 40);
        bus_read(0, d);  chk("R5 status under pd", d, 32'h0);
        bus_read(69, d); chk("R5 result under pd", d, 32'h0);

        // R5 disabled channel
        reg_write(16, 32'h0);
        do_start(16'h0004, 40);
        bus_read(0, d);  chk("R5 disabled status", d, 32'h0);

        // R3/R4 single conversion
        do_start(16'h0020, 40);
        bus_read(69, d); chk("R4 result", d, {1'b1, 19'h0, model_code(3'd7)});
        bus_read(0, d);  chk("R4 status bit", d, 32'h0000_0020);
        ref_fresh[5] = 1'b0;

        // R7 fresh flag consumed
        bus_read(69, d); chk("R7 flag cleared", d, {20'h0, model_code(3'd7)});

        // R8 write-one-to-clear
        reg_write(0, 32'h0);
        bus_read(0, d); chk("R8 zero write", d, 32'h0000_0020);
        reg_write(0, 32'h0000_0020);
        bus_read(0, d); chk("R8 clear", d, 32'h0);

        // R6 ordering with distinct selectors
        reg_write(51, 32'h0000_8001);
        reg_write(57, 32'h0000_8004);
        reg_write(62, 32'h0000_8006);
        do_start(16'h4208, 120);
        check_all();

        // Random phase
        for (int it = 0; it < 15; it++) begin
            nonce = 12'($urandom);
            for (int j = 0; j < 6; j++) reg_write(48 + int'($urandom % 16), $urandom);
            reg_write(16, ($urandom % 4 == 0) ? 32'h8 : 32'h0);
            do_start(16'($urandom), 480);
            check_all();
            reg_write(0, {16'h0, 16'($urandom)});
            bus_read(0, d); chk("R8 random clear", d, {16'h0, ref_status});
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule